// File: doc/BRIEF.md
# Combinational Integer ALU

This block is a purely combinational arithmetic and logic unit for a 32-bit integer datapath. A 4-bit operation code chooses one of six functions on two operands: bitwise AND, bitwise OR, bitwise NOR, two's-complement addition, two's-complement subtraction, and signed set-on-less-than. Besides the result it drives a zero flag and a signed-overflow flag. A branch unit can use the zero flag after a subtraction to test for equality. Overflow is only reported. Whether it traps is decided by control logic outside this block.

Internally the block is a row of identical one-bit slices sharing one ripple carry chain. Each slice can invert either operand before use. Subtraction and the comparison add the inverted second operand with a carry-in of one. NOR is the AND of both inverted operands. There is no clock, no state and no handshake: outputs follow the inputs within the same cycle. The operand width is a parameter with a default of 32.

Top module: `alu32`

## Requirements
- R1: Code 4'b0000 drives the result to the bitwise AND of `a_i` and `b_i`.
- R2: Code 4'b0001 drives the result to the bitwise OR of `a_i` and `b_i`.
- R3: Code 4'b0010 drives the result to `a_i + b_i`, modulo 2^32.
- R4: Code 4'b0110 drives the result to `a_i - b_i`, modulo 2^32, which equals `a_i + ~b_i + 1`.
- R5: Code 4'b0111 drives result bit 0 to 1 when `a_i` is less than `b_i` as signed two's-complement numbers, and to 0 otherwise. Bits 31..1 are 0. The answer is correct even when `a_i - b_i` overflows.
- R6: Code 4'b1100 drives the result to the bitwise NOR of `a_i` and `b_i`.
- R7: `zero_o` is 1 exactly when every bit of `result_o` is 0, for every code.
- R8: For addition, `ovf_o` is 1 exactly when both operands have the same sign bit and the result's sign bit differs from it. Operands of opposite sign never raise it.
- R9: For subtraction, `ovf_o` is 1 exactly when the operands' sign bits differ and the result's sign bit differs from that of `a_i`.
- R10: `ovf_o` is 0 for AND, OR, NOR and set-on-less-than, whatever the operands.
- R11: Any of the ten codes not listed above drives the result to zero and `ovf_o` to 0, so `zero_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest case to reach is a comparison whose underlying subtraction overflows. There the raw sign of `a_i - b_i` gives the wrong answer, so only the sign-correction path decides the output. Random operands rarely produce it. The stimulus forces it directly by pairing the most negative value with large positive values, in both orders. It also runs a full cross of corner operands: zero, one, minus one, the two signed extremes and alternating bit patterns. This cross covers every sign combination for both flags.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic     legal;
    logic     inv_a;
    logic     inv_b;
    logic     carry_in;
    alu_sel_e sel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctrl_t  ctrl_o
);
  // Code bit 3 inverts a, bit 2 inverts b and feeds the carry-in,
  // bits 1:0 pick the output source. Only six codes are legal.
  always_comb begin
    ctrl_o = '{legal: 1'b0, inv_a: 1'b0, inv_b: 1'b0, carry_in: 1'b0, sel: SEL_AND};
    case (op_i)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: begin
        ctrl_o.legal    = 1'b1;
        ctrl_o.inv_a    = op_i[3];
        ctrl_o.inv_b    = op_i[2];
        ctrl_o.carry_in = op_i[2];
        ctrl_o.sel      = alu_sel_e'(op_i[1:0]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic a_i,
  input  logic b_i,
  input  logic inv_a_i,
  input  logic inv_b_i,
  input  logic carry_i,
  output logic and_o,
  output logic or_o,
  output logic sum_o,
  output logic carry_o
);
  logic ax, bx;

  always_comb begin
    ax      = a_i ^ inv_a_i;
    bx      = b_i ^ inv_b_i;
    and_o   = ax & bx;
    or_o    = ax | bx;
    sum_o   = ax ^ bx ^ carry_i;
    carry_o = (ax & bx) | (ax & carry_i) | (bx & carry_i);
  end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_ctrl_t        ctrl_i,
  input  logic [WIDTH-1:0] and_i,
  input  logic [WIDTH-1:0] or_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             carry_msb_in_i,
  input  logic             carry_out_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  logic ovf_raw;
  logic less;

  always_comb begin
    // Signed overflow: carry into the sign bit differs from carry out.
    ovf_raw = carry_msb_in_i ^ carry_out_i;
    // Sign of a-b, corrected when the subtraction overflowed.
    less    = sum_i[WIDTH-1] ^ ovf_raw;
    unique case (ctrl_i.sel)
      SEL_AND:  result_o = and_i;
      SEL_OR:   result_o = or_i;
      SEL_SUM:  result_o = sum_i;
      SEL_LESS: result_o = {{(WIDTH-1){1'b0}}, less};
      default:  result_o = '0;
    endcase
    if (!ctrl_i.legal) result_o = '0;
    ovf_o  = ctrl_i.legal && (ctrl_i.sel == SEL_SUM) && ovf_raw;
    zero_o = ~|result_o;
  end
endmodule

// File: rtl/alu32.sv
module alu32
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic [WIDTH-1:0] sum_v;

  alu_decode u_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign carry[0] = ctrl.carry_in;

  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    alu_bit_slice u_slice (
      .a_i     (a_i[g]),
      .b_i     (b_i[g]),
      .inv_a_i (ctrl.inv_a),
      .inv_b_i (ctrl.inv_b),
      .carry_i (carry[g]),
      .and_o   (and_v[g]),
      .or_o    (or_v[g]),
      .sum_o   (sum_v[g]),
      .carry_o (carry[g+1])
    );
  end

  alu_result_mux #(.WIDTH(WIDTH)) u_mux (
    .ctrl_i         (ctrl),
    .and_i          (and_v),
    .or_i           (or_v),
    .sum_i          (sum_v),
    .carry_msb_in_i (carry[MSB]),
    .carry_out_i    (carry[WIDTH]),
    .result_o       (result_o),
    .zero_o         (zero_o),
    .ovf_o          (ovf_o)
  );
endmodule

// File: rtl/alu32_checker.sv
module alu32_checker
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic legal;
  always_comb legal = op_i inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR};

  always_comb begin
    if (op_i == OP_AND)
      p_and_r1: assert (result_o == (a_i & b_i));
    if (op_i == OP_ADD)
      p_add_r3: assert (result_o == a_i + b_i);
    if (op_i == OP_SLT)
      p_slt_upper_r5: assert (result_o[WIDTH-1:1] == '0);
    if (op_i == OP_SUB && a_i == b_i)
      p_equal_zero_r7: assert (zero_o);
    if (op_i == OP_ADD && a_i[MSB] != b_i[MSB])
      p_add_mixed_r8: assert (!ovf_o);
    if (op_i == OP_SUB && a_i[MSB] == b_i[MSB])
      p_sub_same_r9: assert (!ovf_o);
    if (op_i inside {OP_AND, OP_OR, OP_NOR, OP_SLT})
      p_no_overflow_r10: assert (!ovf_o);
    if (!legal)
      p_undef_r11: assert (result_o == '0 && !ovf_o && zero_o);
  end
endmodule

bind alu32 alu32_checker #(.WIDTH(WIDTH)) u_checker (
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/alu32_test.sv
`timescale 1ns/1ps
module alu32_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [3:0]   op;
  logic [W-1:0] a, b;
  logic [W-1:0] res;
  logic         zf, of;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  alu32 #(.WIDTH(W)) uut (
    .op_i (op), .a_i (a), .b_i (b),
    .result_o (res), .zero_o (zf), .ovf_o (of)
  );

  logic [W-1:0] corners [8];
  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h8000_0000; corners[5] = 32'h5555_5555;
    corners[6] = 32'hAAAA_AAAA; corners[7] = 32'h1234_5678;
  end

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, op, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    #5;
  endtask

  task automatic t_idle;
    apply(4'b0000, '0, '0);
    check("R1 idle result", res, '0);
    check("R7 idle zero", {31'b0, zf}, 32'd1);
    check("R10 idle ovf", {31'b0, of}, 32'd0);
  endtask

  task automatic t_logic;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        apply(4'b0000, corners[i], corners[j]);
        check("R1 and", res, corners[i] & corners[j]);
        check("R10 and ovf", {31'b0, of}, 32'd0);
        apply(4'b0001, corners[i], corners[j]);
        check("R2 or", res, corners[i] | corners[j]);
        check("R10 or ovf", {31'b0, of}, 32'd0);
        apply(4'b1100, corners[i], corners[j]);
        check("R6 nor", res, ~(corners[i] | corners[j]));
        check("R7 nor zero", {31'b0, zf}, {31'b0, (~(corners[i] | corners[j])) == 0});
        check("R10 nor ovf", {31'b0, of}, 32'd0);
      end
  endtask

  task automatic t_add;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        logic [W-1:0] s;
        logic         v;
        s = corners[i] + corners[j];
        v = (corners[i][31] == corners[j][31]) && (s[31] != corners[i][31]);
        apply(4'b0010, corners[i], corners[j]);
        check("R3 add", res, s);
        check("R8 add ovf", {31'b0, of}, {31'b0, v});
        check("R7 add zero", {31'b0, zf}, {31'b0, s == 0});
      end
    apply(4'b0010, 32'h7FFF_FFFF, 32'h1);
    check("R8 max+1", {31'b0, of}, 32'd1);
    check("R3 max+1", res, 32'h8000_0000);
    apply(4'b0010, 32'hFFFF_FFFF, 32'h1);
    check("R8 -1+1 no ovf", {31'b0, of}, 32'd0);
    check("R7 -1+1 zero", {31'b0, zf}, 32'd1);
  endtask

  task automatic t_sub;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        logic [W-1:0] d;
        logic         v;
        d = corners[i] - corners[j];
        v = (corners[i][31] != corners[j][31]) && (d[31] != corners[i][31]);
        apply(4'b0110, corners[i], corners[j]);
        check("R4 sub", res, d);
        check("R9 sub ovf", {31'b0, of}, {31'b0, v});
        check("R7 sub zero", {31'b0, zf}, {31'b0, d == 0});
      end
    apply(4'b0110, 32'h0, 32'h8000_0000);
    check("R9 0-min", {31'b0, of}, 32'd1);
    check("R4 0-min", res, 32'h8000_0000);
    apply(4'b0110, 32'h8000_0000, 32'h1);
    check("R9 min-1", {31'b0, of}, 32'd1);
    check("R4 min-1", res, 32'h7FFF_FFFF);
  endtask

  task automatic t_slt;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        logic lt;
        lt = $signed(corners[i]) < $signed(corners[j]);
        apply(4'b0111, corners[i], corners[j]);
        check("R5 slt", res, {31'b0, lt});
        check("R10 slt ovf", {31'b0, of}, 32'd0);
      end
    apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
    check("R5 min<max with ovf", res, 32'd1);
    apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
    check("R5 max<min with ovf", res, 32'd0);
    apply(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    check("R5 max<-1", res, 32'd0);
  endtask

  task automatic t_undef;
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cc;
      cc = 4'(c);
      if (!(cc inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100})) begin
        apply(cc, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        check("R11 undef result", res, '0);
        check("R11 undef ovf", {31'b0, of}, 32'd0);
        check("R7 undef zero", {31'b0, zf}, 32'd1);
      end
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0;
    repeat (2) @(posedge clk);
    t_idle;
    t_logic;
    t_add;
    t_sub;
    t_slt;
    t_undef;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule